// File: doc/BRIEF.md
# Maskable Interrupt Acceptance Unit

This unit sits beside a CPU core and decides when one of its maskable interrupt lines may be taken. Each line delivers one-cycle request pulses. A pulse is caught in a per-line pending flag. Software sets a per-line enable, a per-line debug enable, a global mask bit and a write-enable bit for protected registers. Two mode inputs say whether the core is in real-time emulation and whether it is halted.

On every clock the unit looks at the registered pending, enable and mask state and picks at most one line to accept. While the core runs, or is not in real-time emulation, a line qualifies when it is pending, its enable bit is set and the global mask is clear. With real-time emulation active and the core halted, the global mask is ignored, and a line qualifies when it is pending and both its enable bit and its debug enable bit are set. If more than one line qualifies, the lowest-numbered one wins.

Acceptance raises a one-cycle strobe together with the line number. In the same update the unit clears that line's pending flag and enable bit, sets the global mask and drops the protected-register write enable. Context saving and the vector fetch are the CPU's job. The accept strobe has no ready input: the core must take it in the cycle it appears. No back-pressure exists, because the global mask, which acceptance sets, is what holds off the next request.

Top module: `irq_accept_top`

## Requirements
- R1: After reset, all pending flags, enable bits and debug enable bits are 0, the global mask is 1, the protected-register write enable is 0 and the accept strobe is low.
- R2: A pulse on bit x of `irq_pulse_i` sets bit x of `flag_o` at the next clock edge. The flag stays set until that line is accepted. Acceptance is decided from registered state only, so a pulse leads to acceptance no sooner than two edges later.
- R3: When the halted-debug rule is not in force, a pending line is accepted only if the global mask is 0 and its enable bit is 1. The debug enable bits have no effect under this rule.
- R4: When `rt_mode_i` and `cpu_halted_i` are both 1, a pending line is accepted if its enable bit and its debug enable bit are both 1, whatever the value of the global mask.
- R5: When `rt_mode_i` is 1 and `cpu_halted_i` is 0, the rule of R3 applies.
- R6: On acceptance, `accept_o` is high for exactly that cycle and `accept_line_o` holds the binary line number. In the same cycle the line's flag bit and enable bit read 0, `gmask_o` reads 1 and `prot_wr_en_o` reads 0.
- R7: When several lines qualify at the same edge, the lowest-numbered line is accepted. The others stay pending.
- R8: Under the rule of R3, after an acceptance no further line is accepted until software clears the mask with `mask_clr_i`. A mask cleared at one edge first allows acceptance at the following edge.
- R9: A pulse on a line at the same edge at which that line is accepted leaves its flag bit set.
- R10: `mask_set_i` overrides `mask_clr_i`, and acceptance overrides both. A write to the enable register at an accepting edge takes effect except on the accepted bit, which reads 0. `prot_wr_set_i` overrides `prot_wr_clr_i`, and acceptance overrides both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Synchronous reset, active low |
| irq_pulse_i | input | N_LINES | One-cycle request pulse per line |
| rt_mode_i | input | 1 | Core is in real-time emulation |
| cpu_halted_i | input | 1 | Core is halted |
| en_wr_i | input | 1 | Write strobe for the enable register |
| en_wdata_i | input | N_LINES | New enable register value |
| dbg_en_wr_i | input | 1 | Write strobe for the debug enable register |
| dbg_en_wdata_i | input | N_LINES | New debug enable register value |
| mask_set_i | input | 1 | Set the global mask |
| mask_clr_i | input | 1 | Clear the global mask |
| prot_wr_set_i | input | 1 | Set the protected-register write enable |
| prot_wr_clr_i | input | 1 | Clear the protected-register write enable |
| flag_o | output | N_LINES | Pending flags |
| en_o | output | N_LINES | Enable register |
| dbg_en_o | output | N_LINES | Debug enable register |
| gmask_o | output | 1 | Global mask |
| prot_wr_en_o | output | 1 | Protected-register write enable |
| accept_o | output | 1 | One-cycle acceptance strobe |
| accept_line_o | output | $clog2(N_LINES) | Number of the accepted line, valid while accept_o is high |

## Verification
The bench builds the unit with N_LINES = 8. With only eight lines, random pulses often land on several lines in the same cycle, so the lowest-number choice is exercised. A three-bit line index also reaches its top value, line 7. Directed steps go through every acceptance rule and every same-edge collision between a pulse, an acceptance and a software write. A long random phase then switches the mode inputs and the mask while lines are pending.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

  // Which acceptance rule is in force for the current cycle.
  typedef enum logic [0:0] {
    RULE_STD = 1'b0,  // global mask clear and enable bit set
    RULE_DBG = 1'b1   // enable bit and debug enable bit set, mask ignored
  } accept_rule_e;

  // A set/clear pair for a single software-controlled status bit.
  typedef struct packed {
    logic set;
    logic clr;
  } bit_ctl_t;

  // Next value of a set/clear bit; set dominates clear.
  function automatic logic ctl_next(input logic cur, input bit_ctl_t ctl);
    logic nxt;
    nxt = cur;
    if (ctl.clr) nxt = 1'b0;
    if (ctl.set) nxt = 1'b1;
    return nxt;
  endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N_LINES = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] pulse_i,
  input  logic [N_LINES-1:0] take_oh_i,
  output logic [N_LINES-1:0] flag_o
);

  logic [N_LINES-1:0] flag_q;

  // Each line has its own flop: a new pulse wins over the clear from acceptance.
  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic nxt;
    always_comb begin
      nxt = flag_q[g];
      if (take_oh_i[g]) nxt = 1'b0;
      if (pulse_i[g])   nxt = 1'b1;
    end
    always_ff @(posedge clk_i) begin
      if (!rst_ni) flag_q[g] <= 1'b0;
      else         flag_q[g] <= nxt;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/irq_enable_regs.sv
module irq_enable_regs #(
  parameter int N_LINES = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_wr_i,
  input  logic [N_LINES-1:0] en_wdata_i,
  input  logic               dbg_wr_i,
  input  logic [N_LINES-1:0] dbg_wdata_i,
  input  logic [N_LINES-1:0] take_oh_i,
  output logic [N_LINES-1:0] en_o,
  output logic [N_LINES-1:0] dbg_en_o
);

  logic [N_LINES-1:0] en_q, en_d;
  logic [N_LINES-1:0] dbg_q;

  // The software write is applied first; then the accepted bit is cleared.
  always_comb begin
    en_d = en_wr_i ? en_wdata_i : en_q;
    en_d = en_d & ~take_oh_i;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      en_q  <= '0;
      dbg_q <= '0;
    end else begin
      en_q <= en_d;
      if (dbg_wr_i) dbg_q <= dbg_wdata_i;
    end
  end

  assign en_o     = en_q;
  assign dbg_en_o = dbg_q;

endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_accept_pkg::*;
#(
  parameter int N_LINES = 16,
  localparam int IDX_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic [N_LINES-1:0] flag_i,
  input  logic [N_LINES-1:0] en_i,
  input  logic [N_LINES-1:0] dbg_en_i,
  input  logic               gmask_i,
  input  accept_rule_e       rule_i,
  output logic [N_LINES-1:0] grant_oh_o,
  output logic [IDX_W-1:0]   grant_idx_o,
  output logic               grant_vld_o
);

  logic [N_LINES-1:0] qual;
  logic [N_LINES-1:0] lower_hit;

  for (genvar g = 0; g < N_LINES; g++) begin : g_qual
    logic gate;
    assign gate    = (rule_i == RULE_DBG) ? dbg_en_i[g] : ~gmask_i;
    assign qual[g] = flag_i[g] & en_i[g] & gate;
    // lower_hit[g]: some line below g also qualifies
    if (g == 0) begin : g_first
      assign lower_hit[g] = 1'b0;
    end else begin : g_rest
      assign lower_hit[g] = lower_hit[g-1] | qual[g-1];
    end
  end

  assign grant_oh_o  = qual & ~lower_hit;
  assign grant_vld_o = |qual;

  always_comb begin
    grant_idx_o = '0;
    for (int i = 0; i < N_LINES; i++) begin
      if (grant_oh_o[i]) grant_idx_o = grant_idx_o | IDX_W'(i);
    end
  end

endmodule

// File: rtl/irq_ctrl_state.sv
module irq_ctrl_state
  import irq_accept_pkg::*;
#(
  parameter int N_LINES = 16,
  localparam int IDX_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             grant_vld_i,
  input  logic [IDX_W-1:0] grant_idx_i,
  input  bit_ctl_t         mask_ctl_i,
  input  bit_ctl_t         prot_ctl_i,
  output logic             gmask_o,
  output logic             prot_o,
  output logic             accept_o,
  output logic [IDX_W-1:0] line_o
);

  logic             gmask_q, prot_q, acc_q;
  logic [IDX_W-1:0] line_q;
  logic             gmask_d, prot_d;

  // Acceptance overrides any software request made at the same edge.
  always_comb begin
    gmask_d = ctl_next(gmask_q, mask_ctl_i);
    prot_d  = ctl_next(prot_q, prot_ctl_i);
    if (grant_vld_i) begin
      gmask_d = 1'b1;
      prot_d  = 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      gmask_q <= 1'b1;
      prot_q  <= 1'b0;
      acc_q   <= 1'b0;
      line_q  <= '0;
    end else begin
      gmask_q <= gmask_d;
      prot_q  <= prot_d;
      acc_q   <= grant_vld_i;
      if (grant_vld_i) line_q <= grant_idx_i;
    end
  end

  assign gmask_o  = gmask_q;
  assign prot_o   = prot_q;
  assign accept_o = acc_q;
  assign line_o   = line_q;

endmodule

// File: rtl/irq_accept_top.sv
module irq_accept_top
  import irq_accept_pkg::*;
#(
  parameter int N_LINES = 16,
  localparam int IDX_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] irq_pulse_i,
  input  logic               rt_mode_i,
  input  logic               cpu_halted_i,
  input  logic               en_wr_i,
  input  logic [N_LINES-1:0] en_wdata_i,
  input  logic               dbg_en_wr_i,
  input  logic [N_LINES-1:0] dbg_en_wdata_i,
  input  logic               mask_set_i,
  input  logic               mask_clr_i,
  input  logic               prot_wr_set_i,
  input  logic               prot_wr_clr_i,
  output logic [N_LINES-1:0] flag_o,
  output logic [N_LINES-1:0] en_o,
  output logic [N_LINES-1:0] dbg_en_o,
  output logic               gmask_o,
  output logic               prot_wr_en_o,
  output logic               accept_o,
  output logic [IDX_W-1:0]   accept_line_o
);

  accept_rule_e       rule;
  logic [N_LINES-1:0] grant_oh;
  logic [IDX_W-1:0]   grant_idx;
  logic               grant_vld;
  bit_ctl_t           mask_ctl, prot_ctl;

  // The halted-debug rule needs both real-time emulation and a halted core.
  assign rule     = (rt_mode_i && cpu_halted_i) ? RULE_DBG : RULE_STD;
  assign mask_ctl = '{set: mask_set_i, clr: mask_clr_i};
  assign prot_ctl = '{set: prot_wr_set_i, clr: prot_wr_clr_i};

  irq_flag_bank #(.N_LINES(N_LINES)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pulse_i   (irq_pulse_i),
    .take_oh_i (grant_oh),
    .flag_o    (flag_o)
  );

  irq_enable_regs #(.N_LINES(N_LINES)) u_enables (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_wr_i     (en_wr_i),
    .en_wdata_i  (en_wdata_i),
    .dbg_wr_i    (dbg_en_wr_i),
    .dbg_wdata_i (dbg_en_wdata_i),
    .take_oh_i   (grant_oh),
    .en_o        (en_o),
    .dbg_en_o    (dbg_en_o)
  );

  irq_pick #(.N_LINES(N_LINES)) u_pick (
    .flag_i      (flag_o),
    .en_i        (en_o),
    .dbg_en_i    (dbg_en_o),
    .gmask_i     (gmask_o),
    .rule_i      (rule),
    .grant_oh_o  (grant_oh),
    .grant_idx_o (grant_idx),
    .grant_vld_o (grant_vld)
  );

  irq_ctrl_state #(.N_LINES(N_LINES)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .grant_vld_i (grant_vld),
    .grant_idx_i (grant_idx),
    .mask_ctl_i  (mask_ctl),
    .prot_ctl_i  (prot_ctl),
    .gmask_o     (gmask_o),
    .prot_o      (prot_wr_en_o),
    .accept_o    (accept_o),
    .line_o      (accept_line_o)
  );

endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk #(
  parameter int N_LINES = 16,
  localparam int IDX_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_LINES-1:0] irq_pulse_i,
  input logic               rt_mode_i,
  input logic               cpu_halted_i,
  input logic [N_LINES-1:0] flag_o,
  input logic [N_LINES-1:0] en_o,
  input logic [N_LINES-1:0] dbg_en_o,
  input logic               gmask_o,
  input logic               prot_wr_en_o,
  input logic               accept_o,
  input logic [IDX_W-1:0]   accept_line_o
);

  // State seen at the previous edge, captured here to judge each acceptance.
  logic [N_LINES-1:0] p_flag, p_en, p_dbg;
  logic               p_halt_rule;
  logic [N_LINES-1:0] below;
  logic [N_LINES-1:0] p_gate;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      p_flag      <= '0;
      p_en        <= '0;
      p_dbg       <= '0;
      p_halt_rule <= 1'b0;
    end else begin
      p_flag      <= flag_o;
      p_en        <= en_o;
      p_dbg       <= dbg_en_o;
      p_halt_rule <= rt_mode_i && cpu_halted_i;
    end
  end

  assign below  = (N_LINES'(1) << accept_line_o) - N_LINES'(1);
  assign p_gate = p_halt_rule ? p_dbg : {N_LINES{1'b1}};

  AST_PULSE_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_pulse_i) |=> ((flag_o & $past(irq_pulse_i)) == $past(irq_pulse_i))); // R2

  AST_MASK_BLOCKS_STD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gmask_o && !(rt_mode_i && cpu_halted_i)) |=> !accept_o); // R3

  AST_ACCEPT_WAS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> (p_flag[accept_line_o] && p_en[accept_line_o])); // R6

  AST_HALT_NEEDS_DBG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && p_halt_rule) |-> p_dbg[accept_line_o]); // R4

  AST_ACCEPT_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> (gmask_o && !prot_wr_en_o && !en_o[accept_line_o])); // R6

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && !(rt_mode_i && cpu_halted_i)) |=> !accept_o); // R8

  AST_LOWEST_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> ((p_flag & p_en & p_gate & below) == '0)); // R7

endmodule

bind irq_accept_top irq_accept_chk #(.N_LINES(N_LINES)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .irq_pulse_i   (irq_pulse_i),
  .rt_mode_i     (rt_mode_i),
  .cpu_halted_i  (cpu_halted_i),
  .flag_o        (flag_o),
  .en_o          (en_o),
  .dbg_en_o      (dbg_en_o),
  .gmask_o       (gmask_o),
  .prot_wr_en_o  (prot_wr_en_o),
  .accept_o      (accept_o),
  .accept_line_o (accept_line_o)
);

// File: tb/irq_accept_top_tb_top.sv
`timescale 1ns/1ps
module irq_accept_top_tb_top;

  localparam int N  = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq = '0;
  logic          rt = 1'b0, halted = 1'b0;
  logic          en_wr = 1'b0, dbg_wr = 1'b0;
  logic [N-1:0]  en_wd = '0, dbg_wd = '0;
  logic          m_set = 1'b0, m_clr = 1'b0, p_set = 1'b0, p_clr = 1'b0;

  logic [N-1:0]  flag_o, en_o, dbg_o;
  logic          gmask_o, prot_o, acc_o;
  logic [IW-1:0] line_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  irq_accept_top #(.N_LINES(N)) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .irq_pulse_i (irq),
    .rt_mode_i (rt), .cpu_halted_i (halted),
    .en_wr_i (en_wr), .en_wdata_i (en_wd),
    .dbg_en_wr_i (dbg_wr), .dbg_en_wdata_i (dbg_wd),
    .mask_set_i (m_set), .mask_clr_i (m_clr),
    .prot_wr_set_i (p_set), .prot_wr_clr_i (p_clr),
    .flag_o (flag_o), .en_o (en_o), .dbg_en_o (dbg_o),
    .gmask_o (gmask_o), .prot_wr_en_o (prot_o),
    .accept_o (acc_o), .accept_line_o (line_o)
  );

  // Behavioural reference model, updated at each rising edge.
  bit [N-1:0] r_flag, r_en, r_dbg;
  bit         r_mask, r_prot, r_acc;
  int         r_line;

  always @(posedge clk) begin
    int pick;
    bit halt_rule;
    if (!rst_n) begin
      r_flag = '0; r_en = '0; r_dbg = '0;
      r_mask = 1; r_prot = 0; r_acc = 0; r_line = 0;
    end else begin
      halt_rule = rt && halted;
      pick = -1;
      for (int i = 0; i < N; i++) begin
        if (pick < 0 && r_flag[i] && r_en[i] &&
            (halt_rule ? r_dbg[i] : !r_mask)) pick = i;
      end
      if (en_wr)  r_en  = en_wd;
      if (dbg_wr) r_dbg = dbg_wd;
      if (m_set) r_mask = 1; else if (m_clr) r_mask = 0;
      if (p_set) r_prot = 1; else if (p_clr) r_prot = 0;
      r_acc = (pick >= 0);
      if (pick >= 0) begin
        r_flag[pick] = 0; r_en[pick] = 0;
        r_mask = 1; r_prot = 0; r_line = pick;
      end
      r_flag = r_flag | irq;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // Compare against the model on every clock, after both have updated.
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      chk("R2 flag vs model", 32'(flag_o), 32'(r_flag));
      chk("R6 enable vs model", 32'(en_o), 32'(r_en));
      chk("R4 debug enable vs model", 32'(dbg_o), 32'(r_dbg));
      chk("R8 mask vs model", 32'(gmask_o), 32'(r_mask));
      chk("R10 prot vs model", 32'(prot_o), 32'(r_prot));
      chk("R7 accept vs model", 32'(acc_o), 32'(r_acc));
      if (r_acc) chk("R7 line vs model", 32'(line_o), 32'(r_line));
    end
  end

  // Wait for the edge, sample after it, then clear one-cycle strobes at the falling edge.
  task automatic step();
    @(posedge clk); #1;
    @(negedge clk);
    irq = '0; en_wr = 0; dbg_wr = 0; m_set = 0; m_clr = 0; p_set = 0; p_clr = 0;
  endtask

  // Values here were sampled just after the edge and still hold at the falling edge.
  task automatic acc_is(input string req, input logic a, input int ln);
    chk(req, 32'(acc_o), 32'(a));
    if (a) chk(req, 32'(line_o), 32'(ln));
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired (all requirements)");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 flag", 32'(flag_o), 0); chk("R1 en", 32'(en_o), 0);
    chk("R1 dbg", 32'(dbg_o), 0);   chk("R1 mask", 32'(gmask_o), 1);
    chk("R1 prot", 32'(prot_o), 0); chk("R1 accept", 32'(acc_o), 0);

    en_wr = 1; en_wd = 8'h05; m_clr = 1; p_set = 1; step();
    chk("R10 en write", 32'(en_o), 32'h05); chk("R8 mask clear", 32'(gmask_o), 0);
    chk("R10 prot set", 32'(prot_o), 1);

    irq = 8'h04; step();
    chk("R2 flag set", 32'(flag_o), 32'h04); acc_is("R2 not same edge", 0, 0);
    step();
    acc_is("R3 accept line2", 1, 2);
    chk("R6 flag cleared", 32'(flag_o), 0); chk("R6 en cleared", 32'(en_o), 32'h01);
    chk("R6 mask set", 32'(gmask_o), 1);    chk("R6 prot cleared", 32'(prot_o), 0);
    step();
    acc_is("R6 one cycle", 0, 0);

    irq = 8'h01; step();
    chk("R2 flag line0", 32'(flag_o), 32'h01);
    step(); acc_is("R8 masked", 0, 0);
    step(); acc_is("R8 still masked", 0, 0);
    m_clr = 1; step();
    chk("R8 mask cleared", 32'(gmask_o), 0); acc_is("R8 not at clearing edge", 0, 0);
    step(); acc_is("R8 accept after clear", 1, 0);

    irq = 8'h08; m_clr = 1; step();
    step(); acc_is("R3 enable 0 blocks", 0, 0);
    chk("R3 flag held", 32'(flag_o), 32'h08);
    dbg_wr = 1; dbg_wd = 8'hFF; step();
    acc_is("R3 debug enable irrelevant", 0, 0);

    en_wr = 1; en_wd = 8'hFF; irq = 8'h60; step();
    acc_is("R7 old enable used", 0, 0); chk("R2 flags", 32'(flag_o), 32'h68);
    step();
    acc_is("R7 lowest line3", 1, 3); chk("R7 others pending", 32'(flag_o), 32'h60);
    m_clr = 1; step(); acc_is("R8 clear edge", 0, 0);
    step();
    acc_is("R7 next line5", 1, 5); chk("R7 en", 32'(en_o), 32'hD7);

    m_clr = 1; step();
    irq = 8'h40; step();
    acc_is("R9 accept line6", 1, 6); chk("R9 flag kept", 32'(flag_o), 32'h40);

    rt = 1; halted = 0; en_wr = 1; en_wd = 8'hFF; step();
    step(); acc_is("R5 running uses mask", 0, 0);
    halted = 1; step();
    acc_is("R4 mask ignored", 1, 6); chk("R4 en", 32'(en_o), 32'hBF);
    dbg_wr = 1; dbg_wd = 8'h00; irq = 8'h02; step();
    step(); acc_is("R4 debug enable 0 blocks", 0, 0);
    m_clr = 1; step();
    step(); acc_is("R4 mask clear no help", 0, 0);
    dbg_wr = 1; dbg_wd = 8'h02; step();
    step(); acc_is("R4 accept line1", 1, 1);

    rt = 0; halted = 0; m_set = 1; m_clr = 1; step();
    chk("R10 set beats clear", 32'(gmask_o), 1);
    irq = 8'h80; m_clr = 1; step();
    m_clr = 1; en_wr = 1; en_wd = 8'hFF; step();
    acc_is("R10 accept line7", 1, 7);
    chk("R10 accept beats clear", 32'(gmask_o), 1);
    chk("R10 write minus accepted", 32'(en_o), 32'h7F);

    for (int c = 0; c < 4000; c++) begin
      irq    = (($urandom % 3) == 0) ? N'($urandom) : '0;
      m_clr  = (($urandom % 3) == 0);
      m_set  = (($urandom % 20) == 0);
      en_wr  = (($urandom % 8) == 0);  en_wd  = N'($urandom);
      dbg_wr = (($urandom % 8) == 0);  dbg_wd = N'($urandom);
      p_set  = (($urandom % 6) == 0);  p_clr  = (($urandom % 6) == 0);
      if (($urandom % 25) == 0) rt = ~rt;
      if (($urandom % 25) == 0) halted = ~halted;
      step();
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule